// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This unit executes one integer data-processing instruction per clock. It takes a 32-bit instruction word, a first operand read from the register file, and a second operand that an external shifter has already prepared, together with that shifter's carry-out. It returns the result, a register write-enable, the destination and first-operand register indices, and the condition flags N, Z, C and V. The flags are shown both as the value the next clock edge will load and as the registered current value.

Six operations are implemented: subtract, reverse subtract, add, compare, move and bit-clear. All arithmetic operations share one adder. In the subtract forms, carry means "no borrow". The logical forms take C from the shifter and leave V alone. Flag updates are gated by the instruction's set-flags bit and are suppressed when the destination is register 15. Compare is the exception: it always sets the flags and never writes a register.

Top module: `dp_alu_unit`

## Requirements
- R1: The instruction fields are at fixed positions. `wr_idx` is instruction bits 15:12. `rn_idx` is bits 19:16. The opcode is bits 24:21. The set-flags bit is bit 20. Both index outputs are combinational.
- R2: Opcode 0x2 (subtract) drives `result` = op_a − op_b modulo 2^32 and raises `wr_en`.
- R3: Opcode 0x3 (reverse subtract) drives `result` = op_b − op_a modulo 2^32 and raises `wr_en`.
- R4: For every subtract form, with minuend m, subtrahend s and result r:
  - C = (s ≤ m) as unsigned numbers.
  - V = bit 31 of ((m XOR r) AND (NOT s XOR r)).
  - N = r[31].
  - Z = (r == 0).
- R5: Opcode 0x4 (add) drives `result` = op_a + op_b modulo 2^32 and raises `wr_en`. C is the carry out of bit 31. V is set when both operands have the same sign and the result's sign differs from it. N and Z follow R4.
- R6: Opcode 0xD (move) drives `result` = op_b and raises `wr_en`. N and Z come from op_b, C = `shift_carry`, and V keeps its value.
- R7: Opcode 0xE (bit clear) drives `result` = op_a AND NOT op_b and raises `wr_en`. N and Z come from the result, C = `shift_carry`, and V keeps its value.
- R8: Opcode 0xA (compare) drives `result` = op_a − op_b and never raises `wr_en`. It sets all four flags as in R4, whatever the set-flags bit and the destination field hold.
- R9: For all other implemented opcodes, the flags change only when the set-flags bit is 1 and `wr_idx` is not 15. Otherwise `nzcv_next` equals `nzcv`.
- R10: Any opcode other than 0x2, 0x3, 0x4, 0xA, 0xD and 0xE drives `result` = 0 and `wr_en` = 0, and leaves the flags unchanged.
- R11: The flag vector is packed as {N,Z,C,V}, with N in bit 3 and V in bit 0.
  - `nzcv` loads `nzcv_next` on a rising clock edge while `instr_valid` is 1, and holds while it is 0.
  - `wr_en` is 0 while `instr_valid` is 0.
  - An active-low `rst_n` clears `nzcv` to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | The instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry-out of the external shifter |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register write-enable |
| wr_idx | output | 4 | Destination register index |
| rn_idx | output | 4 | First-operand register index |
| nzcv_next | output | 4 | Flags the next valid edge will load |
| nzcv | output | 4 | Registered flags |

## Verification
The bench sweeps every 4-bit opcode over operand pairs built from zero, one, the signed extremes, all-ones and mixed patterns. These pairs include equal operands, so carry at equality and signed overflow in both directions are covered.

- A design that computed the carry as a borrow, or used a strict comparison, would fail on the equal pairs.
- A reverse subtract that swapped only the result, and not the flag inputs, would report the wrong C and V.

The bench also toggles the set-flags bit and steers the destination field between 3 and 15. A unit that ignored the register-15 suppression, or gated compare's flags by the set-flags bit, would show changed flags where they must hold. A move or bit-clear that touched V would show up once an earlier add or subtract had left V set.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned OPC_W    = 4;
  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned DST_LSB  = 12;
  localparam int unsigned SRC_LSB  = 16;
  localparam int unsigned SBIT_POS = 20;
  localparam int unsigned OPC_LSB  = 21;

  localparam logic [OPC_W-1:0] OPC_SUB = 4'h2;
  localparam logic [OPC_W-1:0] OPC_RSB = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'h4;
  localparam logic [OPC_W-1:0] OPC_CMP = 4'hA;
  localparam logic [OPC_W-1:0] OPC_MOV = 4'hD;
  localparam logic [OPC_W-1:0] OPC_BIC = 4'hE;

  typedef enum logic [1:0] {
    RES_ARITH,
    RES_PASS_B,
    RES_CLEAR,
    RES_NONE
  } res_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [IDX_W-1:0]   src_idx,
  output logic               set_flags,
  output logic               known,
  output logic               is_cmp,
  output logic               do_sub,
  output logic               swap_ops,
  output logic               logic_flags,
  output res_sel_e           res_sel
);
  logic [OPC_W-1:0] opc;

  assign opc       = instr[OPC_LSB +: OPC_W];
  assign dst_idx   = instr[DST_LSB +: IDX_W];
  assign src_idx   = instr[SRC_LSB +: IDX_W];
  assign set_flags = instr[SBIT_POS];

  always_comb begin
    known       = 1'b1;
    is_cmp      = 1'b0;
    do_sub      = 1'b0;
    swap_ops    = 1'b0;
    logic_flags = 1'b0;
    res_sel     = RES_ARITH;
    case (opc)
      OPC_SUB: do_sub = 1'b1;
      OPC_RSB: begin
        do_sub   = 1'b1;
        swap_ops = 1'b1;
      end
      OPC_ADD: do_sub = 1'b0;
      OPC_CMP: begin
        do_sub = 1'b1;
        is_cmp = 1'b1;
      end
      OPC_MOV: begin
        res_sel     = RES_PASS_B;
        logic_flags = 1'b1;
      end
      OPC_BIC: begin
        res_sel     = RES_CLEAR;
        logic_flags = 1'b1;
      end
      default: begin
        known   = 1'b0;
        res_sel = RES_NONE;
      end
    endcase
  end
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] rhs_eff;
  logic [W:0]   total;

  // Subtraction as lhs + ~rhs + 1: the carry out is then "no borrow"
  assign rhs_eff = do_sub ? ~rhs : rhs;
  assign total   = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, do_sub};
  assign sum     = total[W-1:0];
  assign carry   = total[W];
  // Overflow when both effective addends disagree in sign with the sum
  assign ovf     = (lhs[MSB] ^ sum[MSB]) & (rhs_eff[MSB] ^ sum[MSB]);
endmodule

// File: rtl/dp_alu_flagreg.sv
module dp_alu_flagreg #(
  parameter int unsigned FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  logic [FW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic               shift_carry,
  output logic [DATA_W-1:0]  result,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   rn_idx,
  output logic [FLAG_W-1:0]  nzcv_next,
  output logic [FLAG_W-1:0]  nzcv
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [IDX_W-1:0] PC_IDX = '1;

  logic        set_flags, known, is_cmp, do_sub, swap_ops, logic_flags;
  res_sel_e    res_sel;
  logic [DATA_W-1:0] lhs, rhs, sum;
  logic        carry, ovf, upd;
  flags_t      cur, nxt;

  dp_alu_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr       (instr),
    .dst_idx     (wr_idx),
    .src_idx     (rn_idx),
    .set_flags   (set_flags),
    .known       (known),
    .is_cmp      (is_cmp),
    .do_sub      (do_sub),
    .swap_ops    (swap_ops),
    .logic_flags (logic_flags),
    .res_sel     (res_sel)
  );

  // Reverse subtract swaps the operands ahead of the shared subtractor
  assign lhs = swap_ops ? op_b : op_a;
  assign rhs = swap_ops ? op_a : op_b;

  dp_alu_arith #(.W(DATA_W)) u_arith (
    .lhs    (lhs),
    .rhs    (rhs),
    .do_sub (do_sub),
    .sum    (sum),
    .carry  (carry),
    .ovf    (ovf)
  );

  always_comb begin
    case (res_sel)
      RES_ARITH:  result = sum;
      RES_PASS_B: result = op_b;
      RES_CLEAR:  result = op_a & ~op_b;
      default:    result = '0;
    endcase
  end

  assign wr_en = instr_valid & known & ~is_cmp;
  assign upd   = known & (is_cmp | (set_flags & (wr_idx != PC_IDX)));
  assign cur   = flags_t'(nzcv);

  always_comb begin
    nxt = cur;
    if (upd) begin
      nxt.n = result[MSB];
      nxt.z = (result == '0);
      if (logic_flags) begin
        nxt.c = shift_carry;
      end else begin
        nxt.c = carry;
        nxt.v = ovf;
      end
    end
  end

  assign nzcv_next = nxt;

  dp_alu_flagreg #(.FW(FLAG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (instr_valid & upd),
    .d     (nxt),
    .q     (nzcv)
  );

  AST_CMP_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[OPC_LSB +: OPC_W] == OPC_CMP) |-> !wr_en); // R8

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(nzcv)); // R11

  AST_PC_DEST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[DST_LSB +: IDX_W] == PC_IDX
     && instr[OPC_LSB +: OPC_W] != OPC_CMP) |=> $stable(nzcv)); // R9

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[OPC_LSB +: OPC_W] == OPC_SUB && instr[SBIT_POS]
     && instr[DST_LSB +: IDX_W] != PC_IDX)
    |=> nzcv[1] == ($past(op_b) <= $past(op_a))); // R4

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && (instr[OPC_LSB +: OPC_W] == OPC_MOV
                     || instr[OPC_LSB +: OPC_W] == OPC_BIC))
    |=> $stable(nzcv[0])); // R6 R7

  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[OPC_LSB +: OPC_W] != OPC_SUB
     && instr[OPC_LSB +: OPC_W] != OPC_RSB && instr[OPC_LSB +: OPC_W] != OPC_ADD
     && instr[OPC_LSB +: OPC_W] != OPC_CMP && instr[OPC_LSB +: OPC_W] != OPC_MOV
     && instr[OPC_LSB +: OPC_W] != OPC_BIC)
    |-> (!wr_en && nzcv_next == nzcv)); // R10
endmodule

// File: tb/dp_alu_unit_test.sv
module dp_alu_unit_test;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic [31:0] op_a, op_b;
  logic        shift_carry;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  wr_idx, rn_idx, nzcv_next, nzcv;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] mflags;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
    .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .rn_idx(rn_idx),
    .nzcv_next(nzcv_next), .nzcv(nzcv)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h8000_0001;
      6: return 32'h1234_5678;
      default: return 32'hFFFF_0000;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      2: return "R2";
      3: return "R3";
      4: return "R5";
      10: return "R8";
      13: return "R6";
      14: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic run_one(input int op, input bit s, input logic [3:0] rd,
                         input logic [3:0] rn, input logic [31:0] a,
                         input logic [31:0] b, input bit sc);
    logic [31:0] er;
    logic [32:0] wide;
    logic        ewr, impl, upd, c, v, arith;
    logic [3:0]  ef;
    string       ftag;
    @(negedge clk);
    instr_valid = 1'b1;
    instr = {4'hE, 2'b00, rn[0], op[3:0], s, rn, rd, a[11:0] ^ b[11:0]};
    op_a = a; op_b = b; shift_carry = sc;
    impl = 1'b1; arith = 1'b1; c = mflags[1]; v = mflags[0];
    case (op)
      2:  begin er = a - b; c = (b <= a); v = ((a ^ er) & (~b ^ er)) >> 31; end
      3:  begin er = b - a; c = (a <= b); v = ((b ^ er) & (~a ^ er)) >> 31; end
      4:  begin
            wide = {1'b0, a} + {1'b0, b}; er = wide[31:0]; c = wide[32];
            v = (a[31] == b[31]) && (er[31] != a[31]);
          end
      10: begin er = a - b; c = (b <= a); v = ((a ^ er) & (~b ^ er)) >> 31; end
      13: begin er = b; c = sc; arith = 1'b0; end
      14: begin er = a & ~b; c = sc; arith = 1'b0; end
      default: begin er = 32'h0; impl = 1'b0; end
    endcase
    ewr = impl && (op != 10);
    upd = impl && ((op == 10) || (s && rd != 4'hF));
    ef  = upd ? {er[31], er == 32'h0, c, arith ? v : mflags[0]} : mflags;
    if (op == 2 || op == 3 || op == 10) ftag = "R4";
    else if (!upd && impl) ftag = "R9";
    else ftag = op_tag(op);
    #1;
    chk(op_tag(op), "result", result, er);
    chk(op_tag(op), "wr_en", {31'h0, wr_en}, {31'h0, ewr});
    chk("R1", "wr_idx", {28'h0, wr_idx}, {28'h0, rd});
    chk("R1", "rn_idx", {28'h0, rn_idx}, {28'h0, rn});
    chk(ftag, "nzcv_next", {28'h0, nzcv_next}, {28'h0, ef});
    @(posedge clk);
    #1;
    chk("R11", "nzcv", {28'h0, nzcv}, {28'h0, ef});
    mflags = ef;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    op_a = '0; op_b = '0; shift_carry = 1'b0;
    mflags = 4'h0;
    #(CLK_PERIOD * 3);
    #1;
    chk("R11", "reset nzcv", {28'h0, nzcv}, 32'h0);
    chk("R11", "reset wr_en", {31'h0, wr_en}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Full sweep: every opcode, S bit, destination 3 or 15, operand pairs, shifter carry
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
              for (int sc = 0; sc < 2; sc++)
                run_one(op, s[0], d ? 4'hF : 4'h3, 4'(i + 2 * j), pick(i), pick(j), sc[0]);

    // R11: idle cycle holds flags and keeps wr_en low even for a flag-setting compare
    @(negedge clk);
    instr_valid = 1'b0;
    instr = {4'hE, 3'b000, 4'hA, 1'b1, 4'h1, 4'h2, 12'h0};
    op_a = 32'h0; op_b = 32'h1;
    #1;
    chk("R11", "idle wr_en", {31'h0, wr_en}, 32'h0);
    @(posedge clk);
    #1;
    chk("R11", "idle nzcv hold", {28'h0, nzcv}, {28'h0, mflags});

    // R8: compare with S clear and destination 15 still sets flags (0 - 1: N=1, C=0)
    run_one(10, 1'b0, 4'hF, 4'h5, 32'h0, 32'h1, 1'b0);
    chk("R8", "cmp flags forced", {28'h0, nzcv}, 32'h8);

    // R11: asynchronous reset clears flags mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11", "async reset nzcv", {28'h0, nzcv}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule